// File: doc/BRIEF.md
# E1 Trunk Conditioning Substitution Unit

This block sits on the receive path of an E1 framer, after the elastic store and the signaling extraction. It sees one PCM byte per valid cycle, together with the index of the timeslot that byte belongs to, the four-bit ABCD signaling nibble of that timeslot and a flag that says whether the framer has lost frame. It can overwrite the byte and the nibble with programmed values, either one timeslot at a time or across the whole frame.

There are three sources of substitution, checked in a fixed priority. First, a timeslot is conditioned with its own programmed byte and nibble when its own enable is set or the master enable is set. Second, if that does not apply, the frame is out of alignment and the alarm conditioning enable is set, the byte becomes one idle code that all timeslots share, and the nibble becomes the last signaling value seen for that timeslot while the framer was still in frame. Third, in every other case the stream passes through unchanged.

A 32-entry store keeps the frozen signaling. Software programs the block through a simple address, data and write-strobe port. The output is registered and appears one cycle after the input.

Top module: `e1_trunk_cond`

## Requirements
- R1: After reset, out_valid, out_pcm, out_sig and out_ts are 0, and the master enable, the alarm enable and every per-timeslot enable are cleared, so the stream passes through unchanged.
- R2: Each output appears exactly one clock after its input. out_valid follows in_valid and out_ts follows in_ts with that same one-cycle delay.
- R3: When no conditioning source applies to a valid timeslot, out_pcm equals in_pcm and out_sig equals in_sig.
- R4: When a timeslot's own enable is set, that timeslot outputs its programmed data byte and programmed signaling nibble. Other timeslots are not affected.
- R5: When the master enable is set, every timeslot outputs its own programmed data byte and its own programmed nibble.
- R6: When the alarm enable is set, in_oof is 1 and the timeslot is not conditioned by R4 or R5, out_pcm is the common idle code and out_sig is that timeslot's frozen nibble.
- R7: The frozen nibble of a timeslot is the in_sig of its most recent valid input with in_oof = 0. Inputs that arrive while in_oof = 1 do not change it.
- R8: Per-timeslot conditioning, with the master enable ORed into it, takes priority over alarm conditioning. A conditioned timeslot keeps its own byte and nibble even while out of frame with the alarm enable set.
- R9: While the alarm enable is 0, in_oof has no effect on the outputs.
- R10: Register map (7-bit address). Addresses 0 to 31 hold the data byte of timeslot n = address. Addresses 32 to 63 hold the control of timeslot n = address - 32: bit 4 is the enable and bits 3:0 are the nibble. Address 64 holds the master enable in bit 0 and the alarm enable in bit 1. Address 65 holds the idle code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register address |
| cfg_wdata | input | 8 | Register write data |
| in_valid | input | 1 | Input timeslot strobe |
| in_ts | input | 5 | Input timeslot index |
| in_pcm | input | 8 | Input PCM byte |
| in_sig | input | 4 | Input ABCD nibble |
| in_oof | input | 1 | Framer out-of-frame flag |
| out_valid | output | 1 | Output timeslot strobe |
| out_ts | output | 5 | Output timeslot index |
| out_pcm | output | 8 | Conditioned PCM byte |
| out_sig | output | 4 | Conditioned ABCD nibble |

## Verification
The assertions check four things on every cycle: that valid and the timeslot index are delayed by one clock, that a timeslot conditioned by its own enable or by the master enable takes its programmed byte and nibble, that the idle code is selected under alarm conditioning, and that a frozen entry does not change while the framer stays out of frame. Other behaviour can only be shown by the bench's scenarios. These include the values that survive a loss of frame, the decoding of the register addresses, the case where alarm conditioning is disabled during loss of frame, and the case where clearing a timeslot's enable returns it to pass-through.

// File: rtl/e1tc_pkg.sv
package e1tc_pkg;
  typedef enum logic [1:0] {
    SRC_PASS  = 2'd0,
    SRC_TRUNK = 2'd1,
    SRC_IDLE  = 2'd2
  } cond_src_e;

  typedef enum logic [1:0] {
    RGN_DATA   = 2'd0,
    RGN_CTRL   = 2'd1,
    RGN_GLOBAL = 2'd2,
    RGN_NONE   = 2'd3
  } cfg_region_e;
endpackage

// File: rtl/e1tc_cfg_regs.sv
module e1tc_cfg_regs
  import e1tc_pkg::*;
#(
  parameter int NUM_TS = 32,
  parameter int DATA_W = 8,
  parameter int SIG_W  = 4,
  parameter int TS_W   = $clog2(NUM_TS),
  parameter int ADDR_W = TS_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [TS_W-1:0]   rd_ts,
  output logic [DATA_W-1:0] cond_data,
  output logic [SIG_W-1:0]  cond_sig,
  output logic              ts_en,
  output logic              master_en,
  output logic              alarm_en,
  output logic [DATA_W-1:0] idle_code
);
  localparam int EN_BIT = SIG_W;

  logic [DATA_W-1:0] data_mem [NUM_TS];
  logic [SIG_W-1:0]  sig_mem  [NUM_TS];
  logic [NUM_TS-1:0] en_q;

  cfg_region_e     region;
  logic [TS_W-1:0] idx;

  assign region = cfg_region_e'(cfg_addr[ADDR_W-1:TS_W]);
  assign idx    = cfg_addr[TS_W-1:0];

  // Values without reset, kept in RAM
  always_ff @(posedge clk) begin
    if (cfg_we && region == RGN_DATA) data_mem[idx] <= cfg_wdata;
    if (cfg_we && region == RGN_CTRL) sig_mem[idx]  <= cfg_wdata[SIG_W-1:0];
  end

  // Enable and global flops with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      master_en <= 1'b0;
      alarm_en  <= 1'b0;
      idle_code <= '0;
    end else if (cfg_we) begin
      if (region == RGN_CTRL) en_q[idx] <= cfg_wdata[EN_BIT];
      if (region == RGN_GLOBAL && idx == TS_W'(0)) begin
        master_en <= cfg_wdata[0];
        alarm_en  <= cfg_wdata[1];
      end
      if (region == RGN_GLOBAL && idx == TS_W'(1)) idle_code <= cfg_wdata;
    end
  end

  assign cond_data = data_mem[rd_ts];
  assign cond_sig  = sig_mem[rd_ts];
  assign ts_en     = en_q[rd_ts];
endmodule

// File: rtl/e1tc_sig_freeze.sv
module e1tc_sig_freeze #(
  parameter int NUM_TS = 32,
  parameter int SIG_W  = 4,
  parameter int TS_W   = $clog2(NUM_TS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic             oof,
  input  logic [TS_W-1:0]  ts,
  input  logic [SIG_W-1:0] wr_sig,
  output logic [SIG_W-1:0] frz_sig
);
  logic [SIG_W-1:0] frz_mem [NUM_TS];

  always_ff @(posedge clk) begin
    if (!rst && wr_valid && !oof) frz_mem[ts] <= wr_sig;
  end

  assign frz_sig = frz_mem[ts];

  // R7: an entry holds its value while the framer stays out of frame
  a_r7_frozen_hold: assert property (@(posedge clk) disable iff (rst)
    (oof && $past(oof) && ts == $past(ts)) |-> $stable(frz_sig));
endmodule

// File: rtl/e1tc_select.sv
module e1tc_select
  import e1tc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SIG_W  = 4,
  parameter int TS_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [TS_W-1:0]   in_ts,
  input  logic [DATA_W-1:0] in_pcm,
  input  logic [SIG_W-1:0]  in_sig,
  input  logic              in_oof,
  input  logic [DATA_W-1:0] cond_data,
  input  logic [SIG_W-1:0]  cond_sig,
  input  logic              ts_en,
  input  logic              master_en,
  input  logic              alarm_en,
  input  logic [DATA_W-1:0] idle_code,
  input  logic [SIG_W-1:0]  frz_sig,
  output logic              out_valid,
  output logic [TS_W-1:0]   out_ts,
  output logic [DATA_W-1:0] out_pcm,
  output logic [SIG_W-1:0]  out_sig
);
  cond_src_e        src;
  logic [DATA_W-1:0] pcm_d;
  logic [SIG_W-1:0]  sig_d;

  always_comb begin
    if (master_en || ts_en)      src = SRC_TRUNK;
    else if (alarm_en && in_oof) src = SRC_IDLE;
    else                         src = SRC_PASS;
  end

  always_comb begin
    unique case (src)
      SRC_TRUNK: begin pcm_d = cond_data; sig_d = cond_sig; end
      SRC_IDLE:  begin pcm_d = idle_code; sig_d = frz_sig;  end
      default:   begin pcm_d = in_pcm;    sig_d = in_sig;   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ts    <= '0;
      out_pcm   <= '0;
      out_sig   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ts  <= in_ts;
        out_pcm <= pcm_d;
        out_sig <= sig_d;
      end
    end
  end

  // R2: valid and timeslot index delayed by one clock
  a_r2_valid_on: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_valid_off: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r2_ts_delay: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_ts == $past(in_ts));
  // R5/R8: conditioned timeslot takes its programmed values
  a_r5_trunk_values: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (master_en || ts_en)) |=>
      (out_pcm == $past(cond_data) && out_sig == $past(cond_sig)));
  // R6: alarm conditioning selects the idle code
  a_r6_idle_code: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !master_en && !ts_en && alarm_en && in_oof) |=>
      out_pcm == $past(idle_code));
endmodule

// File: rtl/e1_trunk_cond.sv
module e1_trunk_cond #(
  parameter int NUM_TS = 32,
  parameter int DATA_W = 8,
  parameter int SIG_W  = 4,
  localparam int TS_W  = $clog2(NUM_TS),
  localparam int ADDR_W = TS_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              in_valid,
  input  logic [TS_W-1:0]   in_ts,
  input  logic [DATA_W-1:0] in_pcm,
  input  logic [SIG_W-1:0]  in_sig,
  input  logic              in_oof,
  output logic              out_valid,
  output logic [TS_W-1:0]   out_ts,
  output logic [DATA_W-1:0] out_pcm,
  output logic [SIG_W-1:0]  out_sig
);
  logic [DATA_W-1:0] cond_data, idle_code;
  logic [SIG_W-1:0]  cond_sig, frz_sig;
  logic              ts_en, master_en, alarm_en;

  e1tc_cfg_regs #(.NUM_TS(NUM_TS), .DATA_W(DATA_W), .SIG_W(SIG_W),
                  .TS_W(TS_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_ts(in_ts), .cond_data(cond_data),
    .cond_sig(cond_sig), .ts_en(ts_en), .master_en(master_en),
    .alarm_en(alarm_en), .idle_code(idle_code));

  e1tc_sig_freeze #(.NUM_TS(NUM_TS), .SIG_W(SIG_W), .TS_W(TS_W)) u_freeze (
    .clk(clk), .rst(rst), .wr_valid(in_valid), .oof(in_oof), .ts(in_ts),
    .wr_sig(in_sig), .frz_sig(frz_sig));

  e1tc_select #(.DATA_W(DATA_W), .SIG_W(SIG_W), .TS_W(TS_W)) u_sel (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ts(in_ts),
    .in_pcm(in_pcm), .in_sig(in_sig), .in_oof(in_oof),
    .cond_data(cond_data), .cond_sig(cond_sig), .ts_en(ts_en),
    .master_en(master_en), .alarm_en(alarm_en), .idle_code(idle_code),
    .frz_sig(frz_sig), .out_valid(out_valid), .out_ts(out_ts),
    .out_pcm(out_pcm), .out_sig(out_sig));
endmodule

// File: tb/e1_trunk_cond_test.sv
module e1_trunk_cond_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       in_valid = 1'b0;
  logic [4:0] in_ts = '0;
  logic [7:0] in_pcm = '0;
  logic [3:0] in_sig = '0;
  logic       in_oof = 1'b0;
  logic       out_valid;
  logic [4:0] out_ts;
  logic [7:0] out_pcm;
  logic [3:0] out_sig;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  e1_trunk_cond uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ts(in_ts),
    .in_pcm(in_pcm), .in_sig(in_sig), .in_oof(in_oof),
    .out_valid(out_valid), .out_ts(out_ts), .out_pcm(out_pcm),
    .out_sig(out_sig));

  // {ts, pcm, sig, oof, exp_pcm, exp_sig}
  typedef struct packed {
    logic [4:0] ts;
    logic [7:0] pcm;
    logic [3:0] sig;
    logic       oof;
    logic [7:0] exp_pcm;
    logic [3:0] exp_sig;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{5'd1, 8'h11, 4'h2, 1'b0, 8'h11, 4'h2},
    '{5'd5, 8'h22, 4'h3, 1'b0, 8'h3C, 4'h6},
    '{5'd2, 8'h33, 4'hA, 1'b0, 8'h33, 4'hA},
    '{5'd1, 8'h44, 4'hF, 1'b1, 8'h7E, 4'h2},
    '{5'd2, 8'h55, 4'h0, 1'b1, 8'h7E, 4'hA},
    '{5'd5, 8'h66, 4'h1, 1'b1, 8'h3C, 4'h6},
    '{5'd1, 8'h77, 4'h8, 1'b0, 8'h77, 4'h8},
    '{5'd1, 8'h88, 4'h4, 1'b1, 8'h7E, 4'h8}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [6:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [4:0] ts, input logic [7:0] pcm,
                      input logic [3:0] sig, input logic oof);
    in_valid = 1'b1; in_ts = ts; in_pcm = pcm; in_sig = sig; in_oof = oof;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 out_pcm", 32'(out_pcm), 0);
    check("R1 out_sig", 32'(out_sig), 0);
    check("R1 out_ts", 32'(out_ts), 0);
    rst = 1'b0;
    @(negedge clk);
    // R1: enables cleared, so the input passes through; R2 latency
    send(5'd9, 8'h5A, 4'h5, 1'b1);
    check("R1 pcm pass after reset", 32'(out_pcm), 32'h5A);
    check("R1 sig pass after reset", 32'(out_sig), 32'h5);
    check("R2 out_valid", 32'(out_valid), 1);
    check("R2 out_ts", 32'(out_ts), 9);
    @(negedge clk);
    check("R2 valid drops", 32'(out_valid), 0);

    // R10 register map setup
    cfg_write(7'd5, 8'h3C);          // data ts5
    cfg_write(7'd37, 8'h16);         // ctrl ts5: enable, nibble 6
    cfg_write(7'd65, 8'h7E);         // idle code
    cfg_write(7'd64, 8'h02);         // alarm enable
    cfg_write(7'd7, 8'hC3);          // data ts7
    cfg_write(7'd39, 8'h0B);         // ctrl ts7: no enable, nibble B

    // table walk: R3 R4 R6 R7 R8
    foreach (VECS[i]) begin
      send(VECS[i].ts, VECS[i].pcm, VECS[i].sig, VECS[i].oof);
      check($sformatf("R3/R4/R6/R7/R8 vec%0d pcm", i), 32'(out_pcm), 32'(VECS[i].exp_pcm));
      check($sformatf("R3/R4/R6/R7/R8 vec%0d sig", i), 32'(out_sig), 32'(VECS[i].exp_sig));
    end

    // R4: ts7 not enabled alone, passes through
    send(5'd7, 8'h41, 4'h3, 1'b0);
    check("R4 other ts pcm", 32'(out_pcm), 32'h41);

    // R5 master enable
    cfg_write(7'd64, 8'h03);
    send(5'd7, 8'h42, 4'h1, 1'b0);
    check("R5 master pcm", 32'(out_pcm), 32'hC3);
    check("R5 master sig", 32'(out_sig), 32'hB);
    // R8 master beats alarm during oof
    send(5'd7, 8'h43, 4'h2, 1'b1);
    check("R8 master over idle pcm", 32'(out_pcm), 32'hC3);
    check("R8 master over idle sig", 32'(out_sig), 32'hB);

    // R9 alarm disabled: oof ignored, no freeze update for ts2
    cfg_write(7'd64, 8'h00);
    send(5'd2, 8'h99, 4'hC, 1'b1);
    check("R9 oof ignored pcm", 32'(out_pcm), 32'h99);
    check("R9 oof ignored sig", 32'(out_sig), 32'hC);
    // R7 frozen value still the last in-frame nibble
    cfg_write(7'd64, 8'h02);
    send(5'd2, 8'h12, 4'h7, 1'b1);
    check("R7 frozen kept pcm", 32'(out_pcm), 32'h7E);
    check("R7 frozen kept sig", 32'(out_sig), 32'hA);

    // R10: clearing ts5 enable returns it to pass-through
    cfg_write(7'd37, 8'h06);
    send(5'd5, 8'hE1, 4'hD, 1'b0);
    check("R10 enable cleared pcm", 32'(out_pcm), 32'hE1);
    check("R10 enable cleared sig", 32'(out_sig), 32'hD);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule